// File: doc/BRIEF.md
# Push-Button Volume Register

This block turns three front-panel push buttons (up, down and mute) into an 8-bit volume register. Each raw button input crosses into the clock domain through a two-flop synchroniser. A four-state debounce machine then filters it and emits exactly one single-cycle press pulse each time a press becomes stable. A decoder turns the three press pulses into one event per cycle. The register core applies that event to a 6-bit saturating level and a mute flag. Software can read and write the same register over a plain register port.

The debounce machine has four states. `DB_RELEASED` moves to `DB_PRESS_WAIT` when the synchronised input goes high. `DB_PRESS_WAIT` returns to `DB_RELEASED` if the input drops. It moves to `DB_PRESSED` after `DB_CYCLES` consecutive high cycles, and that transition is the only one that emits a press pulse. `DB_PRESSED` moves to `DB_RELEASE_WAIT` when the input goes low. `DB_RELEASE_WAIT` returns to `DB_PRESSED` if the input rises again. It moves to `DB_RELEASED` after `DB_CYCLES` consecutive low cycles.

The register only holds the value; it does not drive any gain stage. Software polls the change flag, reads the register and applies the level itself. When the shared front-panel pin is used as a general-purpose I/O, `gpio_mode` is high and the buttons are ignored.

Top module: `vol_knob_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 (level 0, unmuted), and `chg_pending` and `chg_pulse` are 0.
- R2: A stable press of up raises the level (bits 5:0) by one. A button held for any length of time gives exactly one change.
- R3: A stable press of down lowers the level by one.
- R4: The level saturates: up at 0x3F stays at 0x3F and down at 0x00 stays at 0x00. A saturated press sets no flag and gives no pulse.
- R5: A press of mute toggles bit 7 (1 = muted) and leaves the level unchanged. This also holds when up or down is pressed in the same cycle as mute.
- R6: Up and down pressed in the same cycle toggle bit 7 and leave the level unchanged.
- R7: Up or down while muted changes only bits 5:0, and bit 7 stays set.
- R8: A button that is high for fewer than `DB_CYCLES` synchronised cycles has no effect on the register.
- R9: While `gpio_mode` is 1, button activity changes neither the register nor `chg_pending`, and gives no `chg_pulse`.
- R10: A write (`reg_wr` = 1) loads bit 7 and bits 5:0 from `reg_wdata`. Bit 6 always reads 0.
- R11: When a write and a button event fall in the same cycle, the event is applied to the written value.
- R12: A button event that alters the value sets `chg_pending` and pulses `chg_pulse` for one cycle, in the cycle the register updates. A read (`reg_rd` = 1) clears `chg_pending`, but a change in the same cycle as the read keeps it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_mode | input | 1 | 1: shared pin used as general I/O, buttons ignored |
| btn_up | input | 1 | Raw up button, active high, asynchronous |
| btn_dn | input | 1 | Raw down button, active high, asynchronous |
| btn_mute | input | 1 | Raw mute button, active high, asynchronous |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | LVL_W+2 | Write data: top bit mute, low LVL_W bits level |
| reg_rd | input | 1 | Software read strobe, clears the change flag |
| reg_rdata | output | LVL_W+2 | Register value: {mute, 0, level} |
| chg_pending | output | 1 | Sticky flag: a button altered the value |
| chg_pulse | output | 1 | One-cycle pulse on each button-caused change |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a software write and a debounced button event. The second is a software read and a button change. The bench counts the register stages from a raw button edge to the press pulse, which is two synchroniser flops and then `DB_CYCLES` cycles in the wait state. It uses that count to drive the write or read strobe in exactly the cycle the press pulse is high. In the write case, `chg_pulse` and the written value with one step applied must appear together in the next cycle. In the read case, `chg_pending` must still be high after the read.

// File: rtl/vol_knob_pkg.sv
package vol_knob_pkg;

    typedef enum logic [1:0] {
        DB_RELEASED,
        DB_PRESS_WAIT,
        DB_PRESSED,
        DB_RELEASE_WAIT
    } db_state_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_UP,
        EV_DOWN,
        EV_MUTE
    } vol_evt_t;

    localparam int unsigned BTN_UP   = 0;
    localparam int unsigned BTN_DN   = 1;
    localparam int unsigned BTN_MUTE = 2;
    localparam int unsigned BTN_N    = 3;

endpackage

// File: rtl/vol_btn_cond.sv
module vol_btn_cond
    import vol_knob_pkg::*;
#(
    parameter int unsigned DB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic press
);

    localparam int unsigned CNT_W = (DB_CYCLES > 1) ? $clog2(DB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

    logic [1:0]       sync_q;
    logic             btn_s;
    db_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[0], btn_raw};
        end
    end

    assign btn_s = sync_q[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_RELEASED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DB_RELEASED: begin
                cnt_d = '0;
                if (btn_s) state_d = DB_PRESS_WAIT;
            end
            DB_PRESS_WAIT: begin
                if (!btn_s) begin
                    state_d = DB_RELEASED;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = DB_PRESSED;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DB_PRESSED: begin
                cnt_d = '0;
                if (!btn_s) state_d = DB_RELEASE_WAIT;
            end
            DB_RELEASE_WAIT: begin
                if (btn_s) begin
                    state_d = DB_PRESSED;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = DB_RELEASED;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        press = 1'b0;
        unique case (state_q)
            DB_PRESS_WAIT:   press = btn_s && (cnt_q == CNT_LAST);
            DB_RELEASED,
            DB_PRESSED,
            DB_RELEASE_WAIT: press = 1'b0;
        endcase
    end

endmodule

// File: rtl/vol_evt_decode.sv
module vol_evt_decode
    import vol_knob_pkg::*;
(
    input  logic             gpio_mode,
    input  logic [BTN_N-1:0] press_vec,
    output vol_evt_t         evt
);

    always_comb begin
        if (gpio_mode) begin
            evt = EV_NONE;
        end else if (press_vec[BTN_MUTE] || (press_vec[BTN_UP] && press_vec[BTN_DN])) begin
            evt = EV_MUTE;
        end else if (press_vec[BTN_UP]) begin
            evt = EV_UP;
        end else if (press_vec[BTN_DN]) begin
            evt = EV_DOWN;
        end else begin
            evt = EV_NONE;
        end
    end

endmodule

// File: rtl/vol_reg_core.sv
module vol_reg_core
    import vol_knob_pkg::*;
#(
    parameter int unsigned LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vol_evt_t         evt,
    input  logic             reg_wr,
    input  logic [LVL_W+1:0] reg_wdata,
    input  logic             reg_rd,
    output logic [LVL_W+1:0] reg_rdata,
    output logic             chg_pending,
    output logic             chg_pulse
);

    localparam int unsigned REG_W = LVL_W + 2;
    localparam logic [LVL_W-1:0] LVL_MAX = '1;
    localparam logic [LVL_W-1:0] LVL_MIN = '0;

    logic [LVL_W-1:0] lvl_q, lvl_d, base_lvl;
    logic             mute_q, mute_d, base_mute;
    logic             pend_q, pend_d;
    logic             pulse_q, changed;

    always_comb begin
        base_mute = reg_wr ? reg_wdata[REG_W-1] : mute_q;
        base_lvl  = reg_wr ? reg_wdata[LVL_W-1:0] : lvl_q;
        mute_d    = base_mute;
        lvl_d     = base_lvl;
        changed   = 1'b0;
        unique case (evt)
            EV_NONE: ;
            EV_UP: begin
                if (base_lvl != LVL_MAX) begin
                    lvl_d   = base_lvl + 1'b1;
                    changed = 1'b1;
                end
            end
            EV_DOWN: begin
                if (base_lvl != LVL_MIN) begin
                    lvl_d   = base_lvl - 1'b1;
                    changed = 1'b1;
                end
            end
            EV_MUTE: begin
                mute_d  = ~base_mute;
                changed = 1'b1;
            end
        endcase
        pend_d = changed | (pend_q & ~reg_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            mute_q  <= 1'b0;
            pend_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            lvl_q   <= lvl_d;
            mute_q  <= mute_d;
            pend_q  <= pend_d;
            pulse_q <= changed;
        end
    end

    assign reg_rdata   = {mute_q, 1'b0, lvl_q};
    assign chg_pending = pend_q;
    assign chg_pulse   = pulse_q;

endmodule

// File: rtl/vol_knob_ctrl.sv
module vol_knob_ctrl
    import vol_knob_pkg::*;
#(
    parameter int unsigned LVL_W     = 6,
    parameter int unsigned DB_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gpio_mode,
    input  logic             btn_up,
    input  logic             btn_dn,
    input  logic             btn_mute,
    input  logic             reg_wr,
    input  logic [LVL_W+1:0] reg_wdata,
    input  logic             reg_rd,
    output logic [LVL_W+1:0] reg_rdata,
    output logic             chg_pending,
    output logic             chg_pulse
);

    logic [BTN_N-1:0] raw_vec;
    logic [BTN_N-1:0] press_vec;
    vol_evt_t         evt;

    always_comb begin
        raw_vec           = '0;
        raw_vec[BTN_UP]   = btn_up;
        raw_vec[BTN_DN]   = btn_dn;
        raw_vec[BTN_MUTE] = btn_mute;
    end

    for (genvar g = 0; g < BTN_N; g++) begin : g_btn
        vol_btn_cond #(
            .DB_CYCLES(DB_CYCLES)
        ) cond_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .btn_raw(raw_vec[g]),
            .press  (press_vec[g])
        );
    end

    vol_evt_decode dec_i (
        .gpio_mode(gpio_mode),
        .press_vec(press_vec),
        .evt      (evt)
    );

    vol_reg_core #(
        .LVL_W(LVL_W)
    ) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .chg_pending(chg_pending),
        .chg_pulse  (chg_pulse)
    );

endmodule

// File: rtl/vol_knob_chk.sv
module vol_knob_chk #(
    parameter int unsigned LVL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gpio_mode,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [LVL_W+1:0] reg_rdata,
    input logic             chg_pending,
    input logic             chg_pulse
);

    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    logic [LVL_W-1:0] lvl;
    assign lvl = reg_rdata[LVL_W-1:0];

    // R12
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> chg_pending);

    // R12
    flag_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chg_pending) |-> $past(reg_rd));

    // R9
    gpio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_mode && !reg_wr) |=> $stable(reg_rdata));

    // R9
    gpio_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_mode |=> !chg_pulse);

    // R4
    top_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && lvl == LVL_MAX) |=> (lvl != '0));

    // R4
    bottom_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && lvl == '0) |=> (lvl != LVL_MAX));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((lvl == $past(lvl)) || (lvl == $past(lvl) + 1'b1) ||
                     (lvl == $past(lvl) - 1'b1)));

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[LVL_W] == 1'b0));

endmodule

bind vol_knob_ctrl vol_knob_chk #(
    .LVL_W(LVL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gpio_mode  (gpio_mode),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .chg_pending(chg_pending),
    .chg_pulse  (chg_pulse)
);

// File: tb/vol_knob_ctrl_tb_top.sv
`timescale 1ns/1ps
module vol_knob_ctrl_tb_top;

    localparam int unsigned DB = 4;
    localparam int unsigned NV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gpio_mode = 1'b0;
    logic       btn_up = 1'b0, btn_dn = 1'b0, btn_mute = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       chg_pending, chg_pulse;

    int total = 0;
    int bad = 0;
    int pulse_cnt = 0;

    always #10 clk = ~clk;

    vol_knob_ctrl #(
        .LVL_W    (6),
        .DB_CYCLES(DB)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gpio_mode  (gpio_mode),
        .btn_up     (btn_up),
        .btn_dn     (btn_dn),
        .btn_mute   (btn_mute),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .chg_pending(chg_pending),
        .chg_pulse  (chg_pulse)
    );

    always @(posedge clk) if (chg_pulse) pulse_cnt <= pulse_cnt + 1;

    // {wr, wdata[7:0], mask[2:0] = {mute,down,up}, expected rdata[7:0]}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 8'h00, 3'b001, 8'h01},
        {1'b0, 8'h00, 3'b001, 8'h02},
        {1'b0, 8'h00, 3'b010, 8'h01},
        {1'b0, 8'h00, 3'b100, 8'h81},
        {1'b0, 8'h00, 3'b001, 8'h82},
        {1'b0, 8'h00, 3'b011, 8'h02},
        {1'b1, 8'h3E, 3'b001, 8'h3F},
        {1'b0, 8'h00, 3'b001, 8'h3F},
        {1'b1, 8'h00, 3'b010, 8'h00},
        {1'b1, 8'hFF, 3'b000, 8'hBF},
        {1'b0, 8'h00, 3'b101, 8'h3F},
        {1'b1, 8'hC5, 3'b010, 8'h84}
    };
    string vec_req [NV] = '{"R2", "R2", "R3", "R5", "R7", "R6",
                            "R10", "R4", "R4", "R10", "R5", "R11"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_btns(input logic [2:0] m);
        btn_up   = m[0];
        btn_dn   = m[1];
        btn_mute = m[2];
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic press(input logic [2:0] m, input int hold);
        @(negedge clk);
        set_btns(m);
        repeat (hold) @(negedge clk);
        set_btns(3'b000);
        repeat (DB + 8) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] prev;
        logic [7:0] base;
        int         p0;
        logic       chg;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1", reg_rdata, 8'h00);
        chk("R1", chg_pending, 1'b0);
        chk("R1", chg_pulse, 1'b0);

        prev = 8'h00;
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            base = prev;
            if (v[19]) begin
                do_write(v[18:11]);
                base = {v[18], 1'b0, v[16:11]};
            end
            p0 = pulse_cnt;
            press(v[10:8], DB + 8);
            chg = (v[7:0] != base);
            chk(vec_req[i], reg_rdata, v[7:0]);
            chk("R12", chg_pending, chg);
            chk("R12", pulse_cnt - p0, chg ? 1 : 0);
            do_read();
            chk("R12", chg_pending, 1'b0);
            prev = v[7:0];
        end

        // R8 glitch shorter than debounce window
        do_write(8'h10);
        p0 = pulse_cnt;
        press(3'b001, 2);
        chk("R8", reg_rdata, 8'h10);
        chk("R8", pulse_cnt - p0, 0);

        // R2 long hold yields one step
        p0 = pulse_cnt;
        press(3'b001, 60);
        chk("R2", reg_rdata, 8'h11);
        chk("R2", pulse_cnt - p0, 1);
        do_read();

        // R9 general-purpose mode ignores buttons
        @(negedge clk);
        gpio_mode = 1'b1;
        p0 = pulse_cnt;
        press(3'b001, DB + 8);
        press(3'b100, DB + 8);
        press(3'b010, DB + 8);
        chk("R9", reg_rdata, 8'h11);
        chk("R9", chg_pending, 1'b0);
        chk("R9", pulse_cnt - p0, 0);
        @(negedge clk);
        gpio_mode = 1'b0;

        // R11 write lands in the same cycle as a down event
        @(negedge clk);
        set_btns(3'b010);
        repeat (DB + 2) @(negedge clk);
        chk("R11", chg_pulse, 1'b0);
        reg_wr = 1'b1;
        reg_wdata = 8'h20;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R11", reg_rdata, 8'h1F);
        chk("R11", chg_pulse, 1'b1);
        set_btns(3'b000);
        repeat (DB + 8) @(negedge clk);
        chk("R11", reg_rdata, 8'h1F);
        do_read();

        // R12 change in the same cycle as a read keeps the flag set
        @(negedge clk);
        set_btns(3'b100);
        repeat (DB + 2) @(negedge clk);
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R12", chg_pending, 1'b1);
        chk("R5", reg_rdata, 8'h9F);
        set_btns(3'b000);
        repeat (DB + 8) @(negedge clk);
        do_read();
        chk("R12", chg_pending, 1'b0);

        finish_run();
    end

endmodule